// File: doc/BRIEF.md
# Transmit Staging Buffer with Word-Port Loading

This block holds one outgoing Ethernet frame between a host and a MAC transmit path. The host loads the frame through a single 32-bit data-port register. Each write to that register lands in the next word of an internal buffer. The host then writes the frame length in bytes and sets a start bit. From that point the block presents the stored bytes one at a time on a byte-wide stream with valid, last and ready signals. It has no framing logic of its own: CRC, padding and the line interface are handled downstream.

The register bus is a plain single-cycle interface: address, write enable, write data, and a read-data output that follows the address with no delay. The block implements a single channel. Its channel-select register stores the value written to it and has no other effect. Because the host always writes whole words, a frame whose length is not a multiple of four leaves up to three unused bytes in its last word. The stream never sends those bytes.

Top module: `tx_stage_buffer`

## Requirements
- R1: After reset the stream shows no valid byte, and the control (0x0C), length (0x18) and channel (0x14) registers all read 0.
- R2: Each write to the data port at offset 0x24 stores one 32-bit word in the next buffer location. Bytes leave the buffer in ascending word order, and within each word the least significant byte goes first.
- R3: A started frame delivers exactly as many bytes as the length register holds. The last flag is high only on the final byte, and valid is low in the cycle after that byte is accepted.
- R4: Bit 0 of the control register at 0x0C starts transmission when written as 1. It reads 1 while a frame is being sent and returns to 0 once the final byte has been accepted.
- R5: When a frame completes, the data-port write position returns to the start of the buffer, so the next frame loads from word 0.
- R6: Data-port writes made while a frame is being sent are ignored. Buffer words that are not rewritten keep their earlier contents.
- R7: The length register at 0x18 reads back the value written to its low 16 bits. A start request made while the length is 0 is ignored.
- R8: The channel-select register at 0x14 stores the low 4 bits written to it and reads them back. It has no effect on the stream.
- R9: While a byte is offered and ready is low, the valid flag, the data byte and the last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWe | input | 1 | Register write enable |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, combinational |
| txData | output | 8 | Outgoing frame byte |
| txValid | output | 1 | txData holds a byte of the current frame |
| txLast | output | 1 | Current byte is the final byte of the frame |
| txReady | input | 1 | Sink accepts the byte in this cycle |

## Verification
The bench sends frames of 1 to 12 bytes. These cover lengths of a whole number of words as well as one to three spare bytes in the last word, so a design that counted words instead of bytes would send too many bytes or raise last in the wrong place. It also sends frames back to back. A design that failed to rewind the write position would load the second frame after the first and stream stale data.

A frame that reuses one old word is sent while a stray data-port write is attempted mid-transmission. A design that accepted that write would corrupt the tail of the frame. The sink also throttles ready, and a design that advanced on valid alone would skip bytes. Finally, a start request with a zero length must leave the stream idle rather than send a huge frame.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int LANES    = WORD_W / 8;
  localparam int LANE_W   = $clog2(LANES);

  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CHAN = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_LEN  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_DATA = 8'h24;

  typedef struct packed {
    logic wordWr;    // store regWdata at write position and advance
    logic ptrClear;  // frame finished: rewind write position
  } dpStrobeT;
endpackage

// File: rtl/tx_stage_ctrl.sv
module tx_stage_ctrl
  import tx_stage_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CH_W  = 4,
  parameter int PTR_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWe,
  input  logic [LEN_W-1:0]      regWdataLo,
  output logic [WORD_W-1:0]     regRdata,
  input  logic                  txReady,
  output logic                  txValid,
  output logic                  txLast,
  output logic [PTR_W+1:0]      byteAddr,
  output dpStrobeT              strb
);
  logic             busy;
  logic [LEN_W-1:0] lenReg;
  logic [CH_W-1:0]  chSel;
  logic [LEN_W-1:0] byteIdx;
  logic             accept;
  logic             lastByte;
  logic             startReq;

  assign accept   = busy && txReady;
  assign lastByte = busy && (byteIdx == lenReg - LEN_W'(1));
  assign startReq = regWe && (regAddr == OFF_CTRL) && regWdataLo[0];

  assign strb.wordWr   = regWe && (regAddr == OFF_DATA) && !busy;
  assign strb.ptrClear = accept && lastByte;

  assign txValid  = busy;
  assign txLast   = lastByte;
  assign byteAddr = byteIdx[PTR_W+1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      lenReg  <= '0;
      chSel   <= '0;
      byteIdx <= '0;
    end else begin
      if (regWe && (regAddr == OFF_LEN) && !busy)
        lenReg <= regWdataLo;
      if (regWe && (regAddr == OFF_CHAN))
        chSel <= regWdataLo[CH_W-1:0];
      if (!busy) begin
        if (startReq && (lenReg != '0)) begin
          busy    <= 1'b1;
          byteIdx <= '0;
        end
      end else if (accept) begin
        if (lastByte) begin
          busy    <= 1'b0;
          byteIdx <= '0;
        end else begin
          byteIdx <= byteIdx + LEN_W'(1);
        end
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_CTRL: regRdata = {{(WORD_W-1){1'b0}}, busy};
      OFF_CHAN: regRdata = {{(WORD_W-CH_W){1'b0}}, chSel};
      OFF_LEN:  regRdata = {{(WORD_W-LEN_W){1'b0}}, lenReg};
      default:  regRdata = '0;
    endcase
  end

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(byteIdx) && $stable(txLast))); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> !txValid); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (byteIdx < lenReg)); // R3
  AST_START_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (lenReg != '0)); // R7
endmodule

// File: rtl/tx_stage_dp.sv
module tx_stage_dp
  import tx_stage_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int PTR_W       = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strb,
  input  logic [WORD_W-1:0] wrData,
  input  logic [PTR_W+1:0]  byteAddr,
  output logic [7:0]        txData
);
  logic [WORD_W-1:0] mem [DEPTH_WORDS];
  logic [PTR_W-1:0]  wrPtr;
  logic [WORD_W-1:0] rdWord;
  logic [7:0]        lane [LANES];

  always_ff @(posedge clk) begin
    if (!rstN)              wrPtr <= '0;
    else if (strb.ptrClear) wrPtr <= '0;
    else if (strb.wordWr)   wrPtr <= wrPtr + PTR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strb.wordWr) mem[wrPtr] <= wrData;
  end

  assign rdWord = mem[byteAddr[PTR_W+1:LANE_W]];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lane[g] = rdWord[8*g +: 8];
  end

  assign txData = lane[byteAddr[LANE_W-1:0]];

  AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrClear |-> !strb.wordWr); // R6
endmodule

// File: rtl/tx_stage_buffer.sv
module tx_stage_buffer
  import tx_stage_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  parameter int LEN_W       = 16,
  parameter int CH_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady
);
  localparam int PTR_W = $clog2(DEPTH_WORDS);

  dpStrobeT         strb;
  logic [PTR_W+1:0] byteAddr;

  tx_stage_ctrl #(.LEN_W(LEN_W), .CH_W(CH_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdataLo(regWdata[LEN_W-1:0]), .regRdata(regRdata),
    .txReady(txReady), .txValid(txValid), .txLast(txLast),
    .byteAddr(byteAddr), .strb(strb)
  );

  tx_stage_dp #(.DEPTH_WORDS(DEPTH_WORDS), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWdata),
    .byteAddr(byteAddr), .txData(txData)
  );
endmodule

// File: tb/test_tx_stage_buffer.sv
module test_tx_stage_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  txData;
  logic        txValid;
  logic        txLast;
  logic        txReady = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] expBytes [64];

  localparam int NFR = 7;
  localparam int FR_LEN [NFR] = '{1, 4, 5, 8, 7, 3, 12};
  localparam logic [31:0] FR_SEED [NFR] = '{32'hA1B2C3D4, 32'h01020304, 32'h55AA33CC,
                                            32'h10203040, 32'hDEADBEEF, 32'h0F1E2D3C, 32'h89ABCDEF};
  localparam bit FR_STALL [NFR] = '{0, 1, 0, 1, 0, 1, 1};

  always #5 clk = ~clk;

  tx_stage_buffer i_tx_stage_buffer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .txData(txData),
    .txValid(txValid), .txLast(txLast), .txReady(txReady)
  );

  function automatic logic [31:0] wordOf(logic [31:0] seed, int k);
    return seed + 32'(k) * 32'h04040404;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic loadWords(logic [31:0] seed, int nWords);
    for (int k = 0; k < nWords; k++) regWrite(8'h24, wordOf(seed, k));
  endtask

  task automatic fillExp(logic [31:0] seed, int len);
    for (int i = 0; i < len; i++) expBytes[i] = 8'(wordOf(seed, i / 4) >> (8 * (i % 4)));
  endtask

  // expBytes must hold the expected stream; injects a data-port write when junk is set
  task automatic rxFrame(int len, bit stall, bit junk, string tag);
    int got = 0;
    int cyc = 0;
    logic [31:0] rd;
    while (got < len && cyc < 500) begin
      @(negedge clk);
      regWe = 1'b0;
      if (junk && cyc == 0) begin
        regAddr = 8'h24; regWdata = 32'hBAD0BAD0; regWe = 1'b1;
      end
      txReady = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (cyc == 1) begin
        regRead(8'h0C, rd);
        check(rd[0] == 1'b1, "R4 busy reads 1", rd, 32'h1);
      end
      if (!txValid) begin
        check(0, {tag, " valid dropped early"}, 32'(got), 32'(len));
        break;
      end
      if (txReady) begin
        check(txData == expBytes[got], {tag, " byte"}, 32'(txData), 32'(expBytes[got]));
        check(txLast == (got == len - 1), "R3 last flag", 32'(txLast), 32'(got == len - 1));
        got++;
      end
      cyc++;
    end
    @(negedge clk);
    regWe = 1'b0;
    txReady = 1'b0;
    #1;
    check(txValid == 1'b0, "R3 valid after final byte", 32'(txValid), 32'h0);
    regRead(8'h0C, rd);
    check(rd[0] == 1'b0, "R4 busy cleared", rd, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(txValid == 1'b0, "R1 valid low", 32'(txValid), 32'h0);
    regRead(8'h0C, rd); check(rd == 32'h0, "R1 ctrl zero", rd, 32'h0);
    regRead(8'h18, rd); check(rd == 32'h0, "R1 len zero", rd, 32'h0);
    regRead(8'h14, rd); check(rd == 32'h0, "R1 chan zero", rd, 32'h0);

    // R7 start with length 0 ignored
    regWrite(8'h0C, 32'h1);
    #1;
    check(txValid == 1'b0, "R7 zero-length start ignored", 32'(txValid), 32'h0);
    regRead(8'h0C, rd); check(rd == 32'h0, "R7 ctrl stays 0", rd, 32'h0);

    // R8 channel select latch
    regWrite(8'h14, 32'hFFFF_FFF5);
    regRead(8'h14, rd); check(rd == 32'h5, "R8 chan readback", rd, 32'h5);
    check(txValid == 1'b0, "R8 no stream effect", 32'(txValid), 32'h0);
    regWrite(8'h14, 32'h0);

    // R2 R3 R5 table of frames, each loaded from buffer start
    for (int f = 0; f < NFR; f++) begin
      loadWords(FR_SEED[f], (FR_LEN[f] + 3) / 4);
      regWrite(8'h18, 32'(FR_LEN[f]));
      regRead(8'h18, rd); check(rd == 32'(FR_LEN[f]), "R7 len readback", rd, 32'(FR_LEN[f]));
      fillExp(FR_SEED[f], FR_LEN[f]);
      regWrite(8'h0C, 32'h1);
      rxFrame(FR_LEN[f], FR_STALL[f], 1'b0, "R2 R5 R9 frame");
    end

    // R6 stale word kept, data-port write during sending ignored
    loadWords(32'h13572468, 2);
    regWrite(8'h18, 32'd12);
    fillExp(32'h13572468, 8);
    for (int i = 8; i < 12; i++) expBytes[i] = 8'(wordOf(FR_SEED[NFR-1], 2) >> (8 * (i % 4)));
    regWrite(8'h0C, 32'h1);
    rxFrame(12, 1'b1, 1'b1, "R6 ignored write");

    // R5 after the previous frame a single word loads at word 0
    loadWords(32'hCAFEF00D, 1);
    regWrite(8'h18, 32'd2);
    fillExp(32'hCAFEF00D, 2);
    regWrite(8'h0C, 32'h1);
    rxFrame(2, 1'b0, 1'b0, "R5 rewind");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule